// File: doc/BRIEF.md
# Single-Cycle Instruction Decoder

This block is the control unit of a single-cycle processor that runs a small MIPS-style instruction set. It takes the 32-bit instruction word and, with no clock and no state, produces every select and enable the datapath needs in that cycle. These cover the next program counter source, the register file write, the immediate extender mode, the ALU operation, the data memory write, the destination register, the write-back source, the ALU second operand and the sub-word store and load widths.

Decoding happens in two stages. A recogniser turns the opcode field into one match line per supported instruction. When the opcode is all zeros it also uses the function field. An encoder then builds each control bit as the OR of the match lines of the instructions that need that bit set. A word that matches nothing, including the all-zero no-operation word, raises no match line, so it writes nothing and falls through to the next sequential address.

Top module: `sc_decoder`

## Requirements
- R1: With opcode 000000, function 100001 decodes as unsigned add: regWrite=1, aluOp=00 (add), dstSel=00 (rd), wbSel=00 (ALU), bSel=0 (register), extMode=00. Function 100011 decodes the same way except aluOp=01 (subtract).
- R2: With opcode 000000 and function 001000 (register jump), npcSel=11 and every write enable and every other field is 0.
- R3: npcSel is 01 only for the branch-if-equal opcode 000100, 10 only for jump-and-link 000011, and 11 only for the register jump. The branch uses aluOp=01 and bSel=0 and writes nothing.
- R4: Immediate add (001001) gives regWrite=1, extMode=01 (sign), aluOp=00, dstSel=01 (rt), wbSel=00, bSel=1 and widths 00. Immediate OR (001101) is the same except extMode=00 (zero) and aluOp=10 (OR).
- R5: Load-upper (001111) gives extMode=10 (immediate into the upper half), aluOp=00, regWrite=1, dstSel=01, bSel=1.
- R6: Loads use extMode=01, aluOp=00, bSel=1, regWrite=1, dstSel=01 and wbSel=01 (memory). loadWidth is 00 for the word load 100011, 01 for the half load 100001 and 10 for the byte load 100000.
- R7: Stores set memWrite=1, regWrite=0, extMode=01, aluOp=00 and bSel=1. storeWidth is 00 for the word store 101011, 01 for the half store 101001 and 10 for the byte store 101000.
- R8: Jump-and-link writes the return address with regWrite=1, dstSel=10 (register 31) and wbSel=10 (PC+4).
- R9: Any other opcode, or opcode 000000 with any other function value (the all-zero word included), drives all 17 control bits to 0.
- R10: Bits 25:6 of an instruction with a nonzero opcode, and bits 25:6 of an R-type word, do not affect any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word being executed |
| npcSel | output | 2 | Next-PC source: 00 sequential, 01 branch, 10 jump-and-link, 11 register |
| regWrite | output | 1 | Register file write enable |
| extMode | output | 2 | Immediate extension: 00 zero, 01 sign, 10 upper half |
| aluOp | output | 2 | ALU operation: 00 add, 01 subtract, 10 OR |
| memWrite | output | 1 | Data memory write enable |
| dstSel | output | 2 | Destination register: 00 rd, 01 rt, 10 register 31 |
| wbSel | output | 2 | Write-back source: 00 ALU, 01 memory, 10 PC+4 |
| bSel | output | 1 | ALU B operand: 0 register, 1 extender |
| storeWidth | output | 2 | Store width: 00 word, 01 half, 10 byte |
| loadWidth | output | 2 | Load width: 00 word, 01 half, 10 byte |

## Verification
The block holds no state, so a bad match line or a missing OR term shows up at the ports in the same evaluation as the word that exposes it. Two kinds of fault matter most. A match line that fires for the wrong opcode or function leaves a stray write enable on an unsupported word. A missing term drops one field of one instruction's control vector. The bench sweeps all 64 opcodes and all 64 function values, each with several scrambled filler fields, and compares the full 17-bit vector against its own table. Any such fault therefore differs from the table on at least one word of the sweep.

// File: rtl/sc_dec_pkg.sv
package sc_dec_pkg;

  localparam int INSTR_W = 32;
  localparam int OPC_W   = 6;
  localparam int FUNCT_W = 6;
  localparam int OPC_LSB = INSTR_W - OPC_W;

  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_ADDIU = 6'b001001;
  localparam logic [OPC_W-1:0] OPC_ORI   = 6'b001101;
  localparam logic [OPC_W-1:0] OPC_LUI   = 6'b001111;
  localparam logic [OPC_W-1:0] OPC_LW    = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_LH    = 6'b100001;
  localparam logic [OPC_W-1:0] OPC_LB    = 6'b100000;
  localparam logic [OPC_W-1:0] OPC_SW    = 6'b101011;
  localparam logic [OPC_W-1:0] OPC_SH    = 6'b101001;
  localparam logic [OPC_W-1:0] OPC_SB    = 6'b101000;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_JAL   = 6'b000011;

  localparam logic [FUNCT_W-1:0] FN_ADDU = 6'b100001;
  localparam logic [FUNCT_W-1:0] FN_SUBU = 6'b100011;
  localparam logic [FUNCT_W-1:0] FN_JR   = 6'b001000;

  // One line per recognised instruction; at most one is high.
  typedef struct packed {
    logic addu;
    logic subu;
    logic jr;
    logic addiu;
    logic ori;
    logic lui;
    logic lw;
    logic lh;
    logic lb;
    logic sw;
    logic sh;
    logic sb;
    logic beq;
    logic jal;
  } matchLines_t;

  // Strobes handed from the control encoder to the datapath side.
  typedef struct packed {
    logic [1:0] npcSel;
    logic       regWrite;
    logic [1:0] extMode;
    logic [1:0] aluOp;
    logic       memWrite;
    logic [1:0] dstSel;
    logic [1:0] wbSel;
    logic       bSel;
    logic [1:0] storeWidth;
    logic [1:0] loadWidth;
  } ctrlStrobes_t;

endpackage

// File: rtl/sc_instr_match.sv
module sc_instr_match
  import sc_dec_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output matchLines_t        hit
);

  logic [OPC_W-1:0]   opcode;
  logic [FUNCT_W-1:0] funct;
  logic               isRtype;

  assign opcode  = instr[INSTR_W-1:OPC_LSB];
  assign funct   = instr[FUNCT_W-1:0];
  assign isRtype = (opcode == OPC_RTYPE);

  always_comb begin
    hit       = '0;
    hit.addu  = isRtype && (funct == FN_ADDU);
    hit.subu  = isRtype && (funct == FN_SUBU);
    hit.jr    = isRtype && (funct == FN_JR);
    hit.addiu = (opcode == OPC_ADDIU);
    hit.ori   = (opcode == OPC_ORI);
    hit.lui   = (opcode == OPC_LUI);
    hit.lw    = (opcode == OPC_LW);
    hit.lh    = (opcode == OPC_LH);
    hit.lb    = (opcode == OPC_LB);
    hit.sw    = (opcode == OPC_SW);
    hit.sh    = (opcode == OPC_SH);
    hit.sb    = (opcode == OPC_SB);
    hit.beq   = (opcode == OPC_BEQ);
    hit.jal   = (opcode == OPC_JAL);
  end

endmodule

// File: rtl/sc_ctrl_encode.sv
module sc_ctrl_encode
  import sc_dec_pkg::*;
(
  input  matchLines_t  hit,
  output ctrlStrobes_t strb
);

  logic anyLoad;
  logic anyStore;
  logic immArith;

  assign anyLoad  = hit.lw | hit.lh | hit.lb;
  assign anyStore = hit.sw | hit.sh | hit.sb;
  assign immArith = hit.addiu | hit.ori | hit.lui;

  // Each bit is the OR of the instructions for which it is set.
  always_comb begin
    strb.npcSel[0]     = hit.beq | hit.jr;
    strb.npcSel[1]     = hit.jal | hit.jr;
    strb.regWrite      = hit.addu | hit.subu | immArith | anyLoad | hit.jal;
    strb.extMode[0]    = hit.addiu | anyLoad | anyStore;
    strb.extMode[1]    = hit.lui;
    strb.aluOp[0]      = hit.subu | hit.beq;
    strb.aluOp[1]      = hit.ori;
    strb.memWrite      = anyStore;
    strb.dstSel[0]     = immArith | anyLoad;
    strb.dstSel[1]     = hit.jal;
    strb.wbSel[0]      = anyLoad;
    strb.wbSel[1]      = hit.jal;
    strb.bSel          = immArith | anyLoad | anyStore;
    strb.storeWidth[0] = hit.sh;
    strb.storeWidth[1] = hit.sb;
    strb.loadWidth[0]  = hit.lh;
    strb.loadWidth[1]  = hit.lb;
  end

endmodule

// File: rtl/sc_decoder.sv
module sc_decoder
  import sc_dec_pkg::*;
(
  input  logic [31:0] instr,
  output logic [1:0]  npcSel,
  output logic        regWrite,
  output logic [1:0]  extMode,
  output logic [1:0]  aluOp,
  output logic        memWrite,
  output logic [1:0]  dstSel,
  output logic [1:0]  wbSel,
  output logic        bSel,
  output logic [1:0]  storeWidth,
  output logic [1:0]  loadWidth
);

  matchLines_t  hit;
  ctrlStrobes_t strb;

  sc_instr_match u_match (
    .instr (instr),
    .hit   (hit)
  );

  sc_ctrl_encode u_encode (
    .hit  (hit),
    .strb (strb)
  );

  assign npcSel     = strb.npcSel;
  assign regWrite   = strb.regWrite;
  assign extMode    = strb.extMode;
  assign aluOp      = strb.aluOp;
  assign memWrite   = strb.memWrite;
  assign dstSel     = strb.dstSel;
  assign wbSel      = strb.wbSel;
  assign bSel       = strb.bSel;
  assign storeWidth = strb.storeWidth;
  assign loadWidth  = strb.loadWidth;

endmodule

// File: rtl/sc_decoder_checker.sv
module sc_decoder_checker (
  input logic [31:0] instr,
  input logic [1:0]  npcSel,
  input logic        regWrite,
  input logic [1:0]  extMode,
  input logic [1:0]  aluOp,
  input logic        memWrite,
  input logic [1:0]  dstSel,
  input logic [1:0]  wbSel,
  input logic        bSel,
  input logic [1:0]  storeWidth,
  input logic [1:0]  loadWidth
);

  logic [5:0] opc;
  logic [5:0] fn;
  logic       known;

  assign opc = instr[31:26];
  assign fn  = instr[5:0];

  always_comb begin
    case (opc)
      6'h00:   known = (fn == 6'h21) || (fn == 6'h23) || (fn == 6'h08);
      6'h09, 6'h0D, 6'h0F, 6'h23, 6'h21, 6'h20,
      6'h2B, 6'h29, 6'h28, 6'h04, 6'h03: known = 1'b1;
      default: known = 1'b0;
    endcase
  end

  always_comb begin
    // R9: unrecognised words write nothing and do not redirect the PC
    assert_unknown_quiet_R9: assert (known || (!regWrite && !memWrite && npcSel == 2'b00))
      else $error("unrecognised instruction produced a write or jump");
    // R7: register and memory writes never coincide
    assert_single_write_R7: assert (!(regWrite && memWrite))
      else $error("register and memory write both asserted");
    // R7: a sub-word store width only accompanies a memory write
    assert_store_width_R7: assert (storeWidth == 2'b00 || memWrite)
      else $error("store width set without memory write");
    // R6: a sub-word load width only accompanies memory write-back
    assert_load_width_R6: assert (loadWidth == 2'b00 || wbSel == 2'b01)
      else $error("load width set without memory write-back");
    // R8: PC+4 write-back always targets register 31
    assert_link_target_R8: assert (wbSel != 2'b10 || (dstSel == 2'b10 && regWrite))
      else $error("link write-back with wrong destination");
    // R3: a redirected PC never writes memory
    assert_jump_no_store_R3: assert (npcSel == 2'b00 || !memWrite)
      else $error("jump or branch raised memory write");
    // R5: upper-half extension only with immediate operand
    assert_upper_imm_R5: assert (extMode != 2'b10 || bSel)
      else $error("upper extension without immediate operand");
  end

endmodule

bind sc_decoder sc_decoder_checker u_checker (
  .instr      (instr),
  .npcSel     (npcSel),
  .regWrite   (regWrite),
  .extMode    (extMode),
  .aluOp      (aluOp),
  .memWrite   (memWrite),
  .dstSel     (dstSel),
  .wbSel      (wbSel),
  .bSel       (bSel),
  .storeWidth (storeWidth),
  .loadWidth  (loadWidth)
);

// File: tb/sc_decoder_bench.sv
module sc_decoder_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int FILLERS    = 4;

  logic        clk = 1'b0;
  logic [31:0] instr;
  logic [1:0]  npcSel;
  logic        regWrite;
  logic [1:0]  extMode;
  logic [1:0]  aluOp;
  logic        memWrite;
  logic [1:0]  dstSel;
  logic [1:0]  wbSel;
  logic        bSel;
  logic [1:0]  storeWidth;
  logic [1:0]  loadWidth;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_decoder u_sc_decoder (
    .instr      (instr),
    .npcSel     (npcSel),
    .regWrite   (regWrite),
    .extMode    (extMode),
    .aluOp      (aluOp),
    .memWrite   (memWrite),
    .dstSel     (dstSel),
    .wbSel      (wbSel),
    .bSel       (bSel),
    .storeWidth (storeWidth),
    .loadWidth  (loadWidth)
  );

  // Vector order: npc2 rw ext2 alu2 mw dst2 wb2 b sw2 lw2
  function automatic logic [16:0] pack(input logic [1:0] n, input logic r,
      input logic [1:0] e, input logic [1:0] a, input logic m,
      input logic [1:0] d, input logic [1:0] w, input logic b,
      input logic [1:0] s, input logic [1:0] l);
    return {n, r, e, a, m, d, w, b, s, l};
  endfunction

  function automatic logic [16:0] refCtrl(input logic [31:0] iw);
    logic [5:0] op;
    logic [5:0] fn;
    op = iw[31:26];
    fn = iw[5:0];
    case (op)
      6'h00: begin
        if (fn == 6'h21)      return pack(2'd0,1,2'd0,2'd0,0,2'd0,2'd0,0,2'd0,2'd0);
        else if (fn == 6'h23) return pack(2'd0,1,2'd0,2'd1,0,2'd0,2'd0,0,2'd0,2'd0);
        else if (fn == 6'h08) return pack(2'd3,0,2'd0,2'd0,0,2'd0,2'd0,0,2'd0,2'd0);
        else                  return '0;
      end
      6'h09: return pack(2'd0,1,2'd1,2'd0,0,2'd1,2'd0,1,2'd0,2'd0);
      6'h0D: return pack(2'd0,1,2'd0,2'd2,0,2'd1,2'd0,1,2'd0,2'd0);
      6'h0F: return pack(2'd0,1,2'd2,2'd0,0,2'd1,2'd0,1,2'd0,2'd0);
      6'h23: return pack(2'd0,1,2'd1,2'd0,0,2'd1,2'd1,1,2'd0,2'd0);
      6'h21: return pack(2'd0,1,2'd1,2'd0,0,2'd1,2'd1,1,2'd0,2'd1);
      6'h20: return pack(2'd0,1,2'd1,2'd0,0,2'd1,2'd1,1,2'd0,2'd2);
      6'h2B: return pack(2'd0,0,2'd1,2'd0,1,2'd0,2'd0,1,2'd0,2'd0);
      6'h29: return pack(2'd0,0,2'd1,2'd0,1,2'd0,2'd0,1,2'd1,2'd0);
      6'h28: return pack(2'd0,0,2'd1,2'd0,1,2'd0,2'd0,1,2'd2,2'd0);
      6'h04: return pack(2'd1,0,2'd0,2'd1,0,2'd0,2'd0,0,2'd0,2'd0);
      6'h03: return pack(2'd2,1,2'd0,2'd0,0,2'd2,2'd2,0,2'd0,2'd0);
      default: return '0;
    endcase
  endfunction

  function automatic string reqOf(input logic [31:0] iw);
    logic [5:0] op;
    logic [5:0] fn;
    op = iw[31:26];
    fn = iw[5:0];
    case (op)
      6'h00: begin
        if (fn == 6'h21 || fn == 6'h23) return "R1/R10";
        else if (fn == 6'h08)           return "R2/R3";
        else                            return "R9";
      end
      6'h09, 6'h0D:        return "R4/R10";
      6'h0F:               return "R5";
      6'h23, 6'h21, 6'h20: return "R6";
      6'h2B, 6'h29, 6'h28: return "R7";
      6'h04:               return "R3";
      6'h03:               return "R3/R8";
      default:             return "R9";
    endcase
  endfunction

  task automatic applyAndCheck(input logic [31:0] iw);
    logic [16:0] got;
    logic [16:0] exp;
    @(negedge clk);
    instr = iw;
    #(CLK_PERIOD/4);
    got = {npcSel, regWrite, extMode, aluOp, memWrite, dstSel, wbSel,
           bSel, storeWidth, loadWidth};
    exp = refCtrl(iw);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s instr=%08h actual=%05h expected=%05h",
               reqOf(iw), iw, got, exp);
    end
  endtask

  function automatic logic [19:0] filler(input int seed);
    logic [31:0] h;
    h = (seed + 1) * 32'h9E37_79B1;
    h = h ^ (h >> 13);
    return h[19:0];
  endfunction

  initial begin
    instr = '0;
    // R9: the all-zero word first
    applyAndCheck(32'h0000_0000);
    applyAndCheck(32'hFFFF_FFFF);
    // Sweep every opcode with several scrambled middle fields (R10)
    for (int op = 0; op < 64; op++) begin
      for (int k = 0; k < FILLERS; k++) begin
        logic [19:0] mid;
        mid = (k == 0) ? 20'h0 : filler(op * FILLERS + k);
        applyAndCheck({op[5:0], mid, mid[5:0] ^ 6'h15});
      end
    end
    // Sweep every function value under opcode zero (R1, R2, R9, R10)
    for (int fn = 0; fn < 64; fn++) begin
      for (int k = 0; k < FILLERS; k++) begin
        logic [19:0] mid;
        mid = (k == 0) ? 20'h0 : filler(1000 + fn * FILLERS + k);
        applyAndCheck({6'b000000, mid, fn[5:0]});
      end
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (!done && cycles > WATCHDOG) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule